// File: doc/BRIEF.md
# UART Interrupt Identification Encoder

This block decides which of a serial port's interrupt sources is presented to the host. Each cycle it takes the interrupt enable bits, the receive error flags, the data-ready and holding-empty status, the receive FIFO fill count and trigger level, a character-timeout pending flag and the modem status change bits. It selects the single most urgent qualified source and registers an identification byte and an active-high interrupt line from that choice.

The block also owns the hidden "transmitter empty" pending flag. The surrounding register file pulses three strobes: a read of the identification register, a write of the transmit holding register, and a write of the enable register. These strobes arm and disarm the flag, so a host that has read the identification once is not interrupted again for the same empty holding register.

Top module: `uart_irq_encoder`

## Requirements
- R1: The five sources are ranked, most urgent first: receive line error, character timeout, receive data available, transmitter empty, modem status change. Only the most urgent qualifying source is reported.
- R2: Identification bits 3:0 carry 0x6 for line error, 0xC for timeout, 0x4 for receive data, 0x2 for transmitter empty, 0x0 for modem status, and 0x1 when nothing is pending. Bits 5:4 are always zero.
- R3: A line error source qualifies only when enable bit 2 is set and at least one of the four error flags (overrun, parity, framing, break) is set.
- R4: The timeout source qualifies only when its pending input is high and enable bit 0 (the receive-data enable) is set.
- R5: With enable bit 0 set and data ready, receive data is reported when FIFOs are off, or when FIFOs are on and the count is at least the trigger level. If FIFOs are on and the count is below the trigger, the result is 0x1, and the transmitter-empty and modem sources are masked.
- R6: A read of the identification register or a write of the holding register clears the transmitter-empty pending flag. The transmitter-empty source needs this flag and enable bit 1.
- R7: A write of the enable register while the holding-empty status is high sets the pending flag. A clear strobe in the same cycle wins, and the write has no effect when holding-empty is low.
- R8: Identification bits 7:6 read 11 when FIFOs are enabled and 00 when they are disabled, independent of the source code.
- R9: The interrupt output is high exactly when the reported code differs from 0x1. The output and the identification byte reflect the inputs sampled at the previous rising clock edge.
- R10: After reset the identification byte is 0x01, the pending flag is clear and the interrupt output is low.
- R11: The modem source qualifies when enable bit 3 is set and at least one of the four change bits is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| enableMask | input | 4 | Interrupt enables: bit0 receive data/timeout, bit1 transmitter empty, bit2 line error, bit3 modem |
| lineErr | input | 4 | Overrun, parity, framing, break flags |
| dataReady | input | 1 | Received data is available |
| holdEmpty | input | 1 | Transmit holding register is empty |
| fifoOn | input | 1 | FIFO mode enabled |
| rxCount | input | CNT_W | Receive FIFO fill count |
| rxTrigger | input | CNT_W | Receive FIFO trigger level |
| timeoutPend | input | 1 | Character timeout pending |
| modemDelta | input | 4 | Modem status change bits |
| idRead | input | 1 | Strobe: identification register read |
| holdWrite | input | 1 | Strobe: holding register write |
| enableWrite | input | 1 | Strobe: enable register write |
| idByte | output | 8 | Interrupt identification byte |
| irqOut | output | 1 | Interrupt request, active high |

## Verification
A wrong pending flag shows at the ports as a stray or missing 0x2 code. The fault appears two edges after the strobe: one edge updates the flag and the next registers the code. A wrong ranking or qualification shows one edge after the inputs settle, as a code that another source should have claimed. The dangerous case is the below-trigger receive state that masks lower sources. The interrupt line is tied to the same code, so a mismatch between the line and the code points to the output register path and not to the encoder.

// File: rtl/irqenc_pkg.sv
package irqenc_pkg;
  localparam int NUM_SRC = 5;
  localparam logic [3:0] CODE_NONE = 4'h1;

  typedef struct packed {
    logic txPending;
    logic flagChanged;
  } ctlStrobes_t;

  function automatic logic [3:0] srcCode(input int idx);
    case (idx)
      0: srcCode = 4'h6;
      1: srcCode = 4'hC;
      2: srcCode = 4'h4;
      3: srcCode = 4'h2;
      default: srcCode = 4'h0;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_ctl.sv
module uart_irq_ctl
  import irqenc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        holdEmpty,
  input  logic        idRead,
  input  logic        holdWrite,
  input  logic        enableWrite,
  output ctlStrobes_t ctl
);
  logic txPend, txPendNext, clearReq, armReq;

  assign clearReq = idRead | holdWrite;
  assign armReq   = enableWrite & holdEmpty;

  always_comb begin
    txPendNext = txPend;
    if (clearReq)    txPendNext = 1'b0;
    else if (armReq) txPendNext = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txPend <= 1'b0;
    else       txPend <= txPendNext;
  end

  assign ctl.txPending   = txPend;
  assign ctl.flagChanged = txPendNext ^ txPend;

  // R6: either clear strobe empties the flag on the next edge
  p_clear_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (idRead || holdWrite) |=> !txPend);
  // R7: enable write with holding-empty arms the flag if no clear
  p_arm_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    (enableWrite && holdEmpty && !idRead && !holdWrite) |=> txPend);
  // R7: without an arm request the flag never rises
  p_no_spurious_arm_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(enableWrite && holdEmpty) |=> !$rose(txPend));
endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import irqenc_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       enableMask,
  input  logic [3:0]       lineErr,
  input  logic             dataReady,
  input  logic             fifoOn,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] rxTrigger,
  input  logic             timeoutPend,
  input  logic [3:0]       modemDelta,
  input  ctlStrobes_t      ctl,
  output logic [7:0]       idByte,
  output logic             irqOut
);
  logic [NUM_SRC-1:0] claim, fire, grant;
  logic [3:0] nextCode, codeReg;
  logic [1:0] fifoBits;
  logic       atTrigger;

  assign atTrigger = !fifoOn || (rxCount >= rxTrigger);

  // claim: source takes the priority slot; fire: it reports its code
  assign claim[0] = enableMask[2] & (|lineErr);
  assign claim[1] = enableMask[0] & timeoutPend;
  assign claim[2] = enableMask[0] & dataReady;
  assign claim[3] = enableMask[1] & ctl.txPending;
  assign claim[4] = enableMask[3] & (|modemDelta);

  assign fire = {claim[4], claim[3], claim[2] & atTrigger, claim[1], claim[0]};

  always_comb begin
    grant = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (claim[i]) grant = NUM_SRC'(1) << i;
    end
  end

  always_comb begin
    nextCode = CODE_NONE;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grant[i] && fire[i]) nextCode = srcCode(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeReg  <= CODE_NONE;
      fifoBits <= 2'b00;
      irqOut   <= 1'b0;
    end else begin
      codeReg  <= nextCode;
      fifoBits <= {2{fifoOn}};
      irqOut   <= (nextCode != CODE_NONE);
    end
  end

  assign idByte = {fifoBits, 2'b00, codeReg};

  // R1: at most one source granted
  p_single_grant_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));
  // R9: interrupt line agrees with the registered code
  p_irq_code_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (idByte[3:0] != CODE_NONE));
  // R3: a qualified line error is always what is reported next
  p_line_err_wins_r3: assert property (@(posedge clk) disable iff (!rstN)
    (enableMask[2] && (|lineErr)) |=> (idByte[3:0] == 4'h6));
  // R8: mode bits follow the FIFO enable one edge later
  p_fifo_bits_r8: assert property (@(posedge clk) disable iff (!rstN)
    fifoOn |=> (idByte[7:6] == 2'b11));
endmodule

// File: rtl/uart_irq_encoder.sv
module uart_irq_encoder
  import irqenc_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       enableMask,
  input  logic [3:0]       lineErr,
  input  logic             dataReady,
  input  logic             holdEmpty,
  input  logic             fifoOn,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] rxTrigger,
  input  logic             timeoutPend,
  input  logic [3:0]       modemDelta,
  input  logic             idRead,
  input  logic             holdWrite,
  input  logic             enableWrite,
  output logic [7:0]       idByte,
  output logic             irqOut
);
  ctlStrobes_t ctl;

  uart_irq_ctl uCtl (
    .clk(clk), .rstN(rstN), .holdEmpty(holdEmpty), .idRead(idRead),
    .holdWrite(holdWrite), .enableWrite(enableWrite), .ctl(ctl)
  );

  uart_irq_dp #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .enableMask(enableMask), .lineErr(lineErr),
    .dataReady(dataReady), .fifoOn(fifoOn), .rxCount(rxCount),
    .rxTrigger(rxTrigger), .timeoutPend(timeoutPend),
    .modemDelta(modemDelta), .ctl(ctl), .idByte(idByte), .irqOut(irqOut)
  );
endmodule

// File: tb/uart_irq_encoder_test.sv
module uart_irq_encoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 5;

  logic clk = 1'b0, rstN = 1'b0;
  logic [3:0] enableMask = '0, lineErr = '0, modemDelta = '0;
  logic dataReady = 0, holdEmpty = 0, fifoOn = 0, timeoutPend = 0;
  logic idRead = 0, holdWrite = 0, enableWrite = 0;
  logic [CNT_W-1:0] rxCount = '0, rxTrigger = '0;
  logic [7:0] idByte;
  logic irqOut;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_encoder #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .enableMask(enableMask), .lineErr(lineErr),
    .dataReady(dataReady), .holdEmpty(holdEmpty), .fifoOn(fifoOn),
    .rxCount(rxCount), .rxTrigger(rxTrigger), .timeoutPend(timeoutPend),
    .modemDelta(modemDelta), .idRead(idRead), .holdWrite(holdWrite),
    .enableWrite(enableWrite), .idByte(idByte), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [3:0] model(input logic [3:0] en, input logic errAny,
      input logic to, input logic dr, input logic fifo, input int cnt,
      input int trig, input logic tx, input logic md);
    if (en[2] && errAny) return 4'h6;
    if (en[0] && to) return 4'hC;
    if (en[0] && dr) return (!fifo || cnt >= trig) ? 4'h4 : 4'h1;
    if (en[1] && tx) return 4'h2;
    if (en[3] && md) return 4'h0;
    return 4'h1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int cntSet [4] = '{0, 3, 4, 5};
    @(negedge clk);
    // R10: reset state
    check("R10 id", idByte, 8'h01);
    check("R10 irq", {7'b0, irqOut}, 8'h00);
    rstN = 1'b1;
    step();
    check("R10 id after release", idByte, 8'h01);

    // R1 R2 R3 R4 R5 R8 R9 R11: sweep with the pending flag clear and set
    rxTrigger = 5'd4;
    for (int tx = 0; tx < 2; tx++) begin
      enableMask = '0; holdEmpty = 1'b1;
      if (tx == 1) enableWrite = 1'b1; else idRead = 1'b1;
      step();
      enableWrite = 1'b0; idRead = 1'b0;
      for (int en = 0; en < 16; en++)
        for (int er = 0; er < 2; er++)
          for (int to = 0; to < 2; to++)
            for (int dr = 0; dr < 2; dr++)
              for (int ff = 0; ff < 2; ff++)
                for (int ci = 0; ci < 4; ci++)
                  for (int md = 0; md < 2; md++) begin
                    logic [3:0] expCode;
                    enableMask  = 4'(en);
                    lineErr     = er[0] ? (4'b1 << ((en + ci) % 4)) : 4'b0;
                    timeoutPend = to[0];
                    dataReady   = dr[0];
                    fifoOn      = ff[0];
                    rxCount     = 5'(cntSet[ci]);
                    modemDelta  = md[0] ? (4'b1 << (ci % 4)) : 4'b0;
                    expCode = model(4'(en), er[0], to[0], dr[0], ff[0],
                                    cntSet[ci], 4, tx[0], md[0]);
                    step();
                    // R1 R2 R5 R8 R11: code and mode bits
                    check("R1/R8 id", idByte, {{2{ff[0]}}, 2'b00, expCode});
                    // R9: line follows code
                    check("R9 irq", {7'b0, irqOut}, {7'b0, expCode != 4'h1});
                  end
    end
    lineErr = '0; timeoutPend = 0; dataReady = 0; modemDelta = '0; fifoOn = 0;

    // R9: output holds old value until the next edge
    enableMask = 4'b0100; lineErr = 4'b0001;
    step();
    lineErr = 4'b0000;
    #1;
    check("R9 before edge", idByte, 8'h06);
    @(negedge clk);
    check("R9 after edge", idByte, 8'h01);

    // R6: flag set, read of id clears it (takes effect two edges later)
    enableMask = 4'b0010; holdEmpty = 1'b1; enableWrite = 1'b1;
    step();
    enableWrite = 1'b0;
    step();
    check("R6 armed", idByte, 8'h02);
    idRead = 1'b1;
    step();
    idRead = 1'b0;
    check("R6 read still shows", idByte, 8'h02);
    step();
    check("R6 read cleared", idByte, 8'h01);

    // R6: holding write clears
    enableWrite = 1'b1;
    step();
    enableWrite = 1'b0;
    step();
    check("R6 re-armed", idByte, 8'h02);
    holdWrite = 1'b1;
    step();
    holdWrite = 1'b0;
    step();
    check("R6 write cleared", {7'b0, irqOut}, 8'h00);

    // R7: enable write with holding not empty does nothing
    holdEmpty = 1'b0; enableWrite = 1'b1;
    step();
    enableWrite = 1'b0;
    step();
    check("R7 no arm when busy", idByte, 8'h01);

    // R7: clear wins over arm in the same cycle
    holdEmpty = 1'b1; enableWrite = 1'b1; idRead = 1'b1;
    step();
    enableWrite = 1'b0; idRead = 1'b0;
    step();
    check("R7 clear wins", idByte, 8'h01);

    // R10: reset mid-run clears the flag
    enableWrite = 1'b1;
    step();
    enableWrite = 1'b0;
    rstN = 1'b0;
    step();
    rstN = 1'b1;
    step();
    check("R10 flag cleared by reset", idByte, 8'h01);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule